// File: doc/BRIEF.md
# Reduction Correction Factor Unit

This unit forms the integer correction κ that turns a sum-of-residues result into the exact remainder modulo a field prime p. It also produces, for every residue channel j, the term (κ·(−p mod m_j)) mod m_j. That term is added to the channel accumulator to finish the reduction. The weighted terms γ_i arrive one per cycle beside the main accumulation. The unit multiplies each term by a stored narrow constant, floor((M_i mod p) / 2^(W−T)). It sums the products and drops the low T bits of the total. Because these constants are residues of p truncated by W−T bits, each one fits in T bits.

A run opens with a `start` strobe, followed by N strobed terms. Two cycles after the last term is taken, `kappa` and all per-channel correction terms are presented together with a one-cycle `done` pulse. The constants, the negated-prime residues and the channel moduli come in as parameters. Each channel modulus has the form 2^n − 2^t_j − 1, so the reducer folds the high half back in with shifts and adds and needs no divider. The result width is n + ceil(log2 N) bits, and the reducer gives the exact residue for any κ in that range.

Top module: `kappa_corr`

## Requirements
- R1: `kappa` equals floor((Σ γ_k·C_k) / 2^T) over the N terms accepted in a run, where the k-th accepted term (k = 0 first) is weighted by constant C_k taken from bits [k·T +: T] of `CONST_TAB`.
- R2: `start` clears the running sum and the term count. A `gamma_vld` in the same cycle as `start` is discarded. A `start` in the middle of a run drops every term taken so far.
- R3: Once N terms have been taken, further `gamma_vld` strobes are ignored until the next `start`: the result does not change and no extra `done` appears.
- R4: Bits [j·n +: n] of `corr` equal (κ·P_j) mod m_j, where P_j = bits [j·n +: n] of `NEGP_TAB` and m_j = 2^n − 2^t_j − 1 with t_j = bits [j·8 +: 8] of `MOD_T`. The value is always below m_j.
- R5: `done` is a single-cycle pulse, high in the cycle after the second rising edge that follows the edge accepting the N-th term. From that cycle on, `kappa` and `corr` hold the new run's results.
- R6: `kappa` and `corr` keep their last results through a later `start` and through that run's first terms.
- R7: After reset `done` is low and `kappa` and `corr` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Opens a new run, clears the sum |
| gamma_vld | input | 1 | Qualifies `gamma` |
| gamma | input | RES_W | One weighted term γ_k |
| kappa | output | RES_W+clog2(N_CH) | Correction integer κ |
| corr | output | N_CH·RES_W | Per-channel (κ·(−p)) mod m_j, channel 0 in the low bits |
| done | output | 1 | One-cycle result pulse |

## Verification
The sum is registered on the edge that takes the N-th term. κ is registered on the next edge, and the channel terms plus `done` on the edge after that. The results are therefore due two edges after the last term. The driver records that edge number when it queues its independently computed κ and channel terms. The monitor samples on falling edges and checks that each `done` arrives exactly at the recorded edge. It also checks that `done` never appears with nothing queued. The checks on held results and on ignored extra terms read `kappa` and `corr` between runs, before the next `done` can occur.

// File: rtl/kappa_corr.sv
module kappa_corr #(
  parameter int N_CH    = 4,
  parameter int RES_W   = 16,
  parameter int FIELD_W = 32,
  parameter int TRUNC   = 16,
  parameter logic [N_CH*TRUNC-1:0] CONST_TAB = 64'h0001_FFFF_5E27_A3C1,
  parameter logic [N_CH*RES_W-1:0] NEGP_TAB  = 64'h0F0F_7A5C_BEEF_1234,
  parameter logic [N_CH*8-1:0]     MOD_T     = 32'h04_03_02_00,
  localparam int KW = RES_W + $clog2(N_CH)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start,
  input  logic                  gamma_vld,
  input  logic [RES_W-1:0]      gamma,
  output logic [KW-1:0]         kappa,
  output logic [N_CH*RES_W-1:0] corr,
  output logic                  done
);
  localparam int CW    = TRUNC;
  localparam int ACC_W = RES_W + CW + $clog2(N_CH);
  localparam int CNTW  = $clog2(N_CH + 1);
  localparam int IW    = (N_CH > 1) ? $clog2(N_CH) : 1;
  localparam int PW    = KW + RES_W;
  localparam int FOLDS = 4;

  logic [CW-1:0]    ctab [N_CH];
  logic [CNTW-1:0]  cnt_q;
  logic [ACC_W-1:0] acc_q;
  logic [ACC_W-1:0] term;
  logic             take_q, fin_q, done_q;
  logic [KW-1:0]    kap_q;
  logic             accept;

  assign accept = gamma_vld && !start && (cnt_q < CNTW'(N_CH));
  assign term   = ACC_W'(gamma) * ACC_W'(ctab[cnt_q[IW-1:0]]);
  assign kappa  = kap_q;
  assign done   = done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      acc_q  <= '0;
      take_q <= 1'b0;
      fin_q  <= 1'b0;
      done_q <= 1'b0;
      kap_q  <= '0;
    end else begin
      take_q <= 1'b0;
      fin_q  <= take_q;
      done_q <= fin_q;
      if (start) begin
        cnt_q <= '0;
        acc_q <= '0;
      end else if (accept) begin
        acc_q  <= acc_q + term;
        cnt_q  <= cnt_q + 1'b1;
        take_q <= (cnt_q == CNTW'(N_CH - 1));
      end
      if (take_q) kap_q <= acc_q[ACC_W-1:TRUNC];
    end
  end

  genvar j;
  generate
    for (j = 0; j < N_CH; j++) begin : g_ch
      localparam int TJ = int'(MOD_T[j*8 +: 8]);
      localparam logic [RES_W-1:0] MJ = {RES_W{1'b1}} - (RES_W'(1) << TJ);
      localparam logic [PW:0] MJX  = (PW+1)'(MJ);
      localparam logic [PW:0] MASK = (PW+1)'({RES_W{1'b1}});

      logic [PW:0]      x;
      logic [RES_W-1:0] corr_q;

      assign ctab[j] = CONST_TAB[j*CW +: CW];

      always_comb begin
        x = (PW+1)'(kap_q) * (PW+1)'(NEGP_TAB[j*RES_W +: RES_W]);
        for (int f = 0; f < FOLDS; f++)
          x = ((x >> RES_W) << TJ) + (x >> RES_W) + (x & MASK);
        for (int s = 0; s < 2; s++)
          if (x >= MJX) x = x - MJX;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     corr_q <= '0;
        else if (fin_q) corr_q <= x[RES_W-1:0];
      end

      assign corr[j*RES_W +: RES_W] = corr_q;

      a_r4_corr_below_mod: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (corr_q < MJ));
    end
  endgenerate

  a_r2_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (cnt_q == '0 && acc_q == '0));

  a_r3_full_holds_sum: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == CNTW'(N_CH) && !start) |=> $stable(acc_q));

  a_r5_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r6_kappa_held: assert property (@(posedge clk) disable iff (!rst_n)
    !take_q |=> $stable(kappa));

  a_r5_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNTW'(N_CH));
endmodule

// File: tb/kappa_corr_test.sv
module kappa_corr_test;
  localparam int N = 4;
  localparam int RW = 16;
  localparam int KW = RW + 2;
  localparam logic [63:0] CT = 64'h0001_FFFF_5E27_A3C1;
  localparam logic [63:0] NP = 64'h0F0F_7A5C_BEEF_1234;
  localparam logic [31:0] MT = 32'h04_03_02_00;

  logic clk = 0, rst_n = 0, start = 0, gamma_vld = 0;
  logic [RW-1:0] gamma = '0;
  logic [KW-1:0] kappa;
  logic [N*RW-1:0] corr;
  logic done;

  int checks = 0, errors = 0;
  longint cyc = 0;
  longint gv [8];
  logic [KW-1:0]   q_k [$];
  logic [N*RW-1:0] q_c [$];
  longint          q_t [$];

  kappa_corr uut (.clk(clk), .rst_n(rst_n), .start(start), .gamma_vld(gamma_vld),
                  .gamma(gamma), .kappa(kappa), .corr(corr), .done(done));

  always #10 clk = ~clk;

  function automatic longint cst(int i); return longint'(CT[i*16 +: 16]); endfunction
  function automatic longint negp(int j); return longint'(NP[j*16 +: 16]); endfunction
  function automatic longint modj(int j);
    return 65535 - (longint'(1) << int'(MT[j*8 +: 8]));
  endfunction

  task automatic finish_all();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      errors++;
      $display("FAIL watchdog: actual cycle %0d expected under 100000", cyc);
      finish_all();
    end
  end

  always @(negedge clk) if (rst_n && done) begin
    if (q_k.size() == 0) begin
      checks++; errors++;
      $display("FAIL R3/R5 unexpected done: actual 1 expected 0 at cycle %0d", cyc);
    end else begin
      logic [KW-1:0] ek; logic [N*RW-1:0] ec; longint et;
      ek = q_k.pop_front(); ec = q_c.pop_front(); et = q_t.pop_front();
      checks++;
      if (cyc != et) begin errors++;
        $display("FAIL R5 done timing: actual %0d expected %0d", cyc, et); end
      checks++;
      if (kappa != ek) begin errors++;
        $display("FAIL R1 kappa: actual %h expected %h", kappa, ek); end
      checks++;
      if (corr != ec) begin errors++;
        $display("FAIL R4 corr: actual %h expected %h", corr, ec); end
    end
  end

  task automatic run(input int n_extra, input bit clash);
    longint acc = 0, k;
    logic [N*RW-1:0] ec;
    @(negedge clk); start = 1; gamma_vld = clash; gamma = 16'hDEAD;
    @(negedge clk); start = 0; gamma_vld = 0;
    for (int i = 0; i < N; i++) begin
      gamma_vld = 1; gamma = gv[i][15:0];
      acc += longint'(gv[i][15:0]) * cst(i);
      @(negedge clk);
    end
    gamma_vld = 0;
    k = acc >> 16;
    for (int j = 0; j < N; j++) ec[j*16 +: 16] = 16'((k * negp(j)) % modj(j));
    q_k.push_back(KW'(k)); q_c.push_back(ec); q_t.push_back(cyc + 2);
    for (int e = 0; e < n_extra; e++) begin
      gamma_vld = 1; gamma = 16'hFFFF; @(negedge clk);
    end
    gamma_vld = 0;
    repeat (5) @(negedge clk);
  endtask

  task automatic partial(input int n);
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
    for (int i = 0; i < n; i++) begin
      gamma_vld = 1; gamma = 16'h7777; @(negedge clk);
    end
    gamma_vld = 0;
  endtask

  initial begin
    logic [KW-1:0] hk; logic [N*RW-1:0] hc;
    repeat (3) @(negedge clk);
    checks++; if (done !== 1'b0) begin errors++; $display("FAIL R7 done: actual %b expected 0", done); end
    checks++; if (kappa !== '0) begin errors++; $display("FAIL R7 kappa: actual %h expected 0", kappa); end
    checks++; if (corr !== '0) begin errors++; $display("FAIL R7 corr: actual %h expected 0", corr); end
    rst_n = 1;

    for (int i = 0; i < N; i++) gv[i] = 0;          run(0, 0); // R1 zero terms
    for (int i = 0; i < N; i++) gv[i] = 16'hFFFF;   run(0, 0); // R1 max terms
    gv[0] = 16'h1234; gv[1] = 16'h0001; gv[2] = 16'h8000; gv[3] = 16'hFFFE;
    run(0, 1);                                                  // R2 clash on start
    gv[0] = 16'h00FF; gv[1] = 16'hABCD; gv[2] = 16'h0003; gv[3] = 16'h4444;
    run(3, 0);                                                  // R3 extra strobes
    hk = kappa; hc = corr;
    partial(2);                                                 // R6 hold, R2 mid-run restart
    checks++; if (kappa !== hk) begin errors++; $display("FAIL R6 kappa held: actual %h expected %h", kappa, hk); end
    checks++; if (corr !== hc) begin errors++; $display("FAIL R6 corr held: actual %h expected %h", corr, hc); end
    for (int r = 0; r < 6; r++) begin
      for (int i = 0; i < N; i++) gv[i] = longint'($urandom_range(65535));
      run(r % 2, r % 3 == 0);
    end
    repeat (4) @(negedge clk);
    checks++;
    if (q_k.size() != 0) begin errors++;
      $display("FAIL R5 missing done: actual %0d pending expected 0", q_k.size()); end
    finish_all();
  end
endmodule